// File: doc/BRIEF.md
# Packed Element Register File

The block holds 128 general registers of 64 bits and treats them as one flat array of 1024 bytes. Each access names a base register, an element index and an element width of 8, 16, 32 or 64 bits. The element's absolute byte position is the base register's byte address plus the index times the element size. That position fixes the register that holds the element and the byte lane inside it. Narrow elements therefore pack several to a register, and a vector of elements runs on into the registers that follow the base.

There is one combinational read port and one clocked write port. The read port returns its element zero-extended. The write port updates only the byte lanes that the element covers. A write-side adder can add the write operand to the element on the read port and store the sum. The sum wraps at the element width. An access whose element would land beyond the last register is flagged, reads zero and is never written.

Top module: `pkrf_top`

## Requirements
- R1: After reset every byte of every register reads as zero.
- R2: Width codes are 0=8, 1=16, 2=32 and 3=64 bits, giving eb=1,2,4,8 bytes. For base register B and index i, the element starts at byte offset o=8*B+i*eb. It lives in register o/8 and starts at byte lane o%8, where lane 0 holds bits 7:0.
- R3: A write changes only the eb byte lanes the element covers. For example, a 16-bit write to element 0 changes bits 15:0 only, and a 32-bit write to element 0 changes bits 31:0 only.
- R4: The read port returns the element in its low bits, and all bits above the element width are zero.
- R5: With add_i high, the stored value is (read element + wr_data_i) mod 2^(8*eb). At 16 bits, 0xFFFF+1 stores 0, and a register of all ones becomes 0xFFFF_FFFF_FFFF_0000.
- R6: At width code 3 and index 0, a write or an add acts on the whole register as an ordinary 64-bit operation, for example 0x1234+0x1122=0x2356.
- R7: A read of the location being written in the same cycle returns the old data. The new data is visible after the clock edge.
- R8: If the element's register o/8 exceeds 127, the port's error flag is high, that port's read data is zero, and no register changes. This includes an add whose read side is out of range.
- R9: Bits of wr_data_i above the element width have no effect on the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_base_i | input | 7 | Read base register |
| rd_idx_i | input | 7 | Read element index |
| rd_ew_i | input | 2 | Read element width code |
| rd_data_o | output | 64 | Read element, zero-extended |
| rd_err_o | output | 1 | Read element out of range |
| wr_en_i | input | 1 | Write request |
| add_i | input | 1 | Store read element plus wr_data_i instead of wr_data_i |
| wr_base_i | input | 7 | Write base register |
| wr_idx_i | input | 7 | Write element index |
| wr_ew_i | input | 2 | Write element width code |
| wr_data_i | input | 64 | Write operand, low bits used |
| wr_err_o | output | 1 | Write element out of range |

## Verification
A read and a write can name the same bytes in the same cycle. The add path always makes this happen, because it reads an element and writes a sum in one cycle. The bench drives directed cycles with both ports on one register, and a long random run with overlapping narrow elements and out-of-range indices. A byte-array reference model predicts the old read value for the current cycle and the merged bytes for the next, and the bench compares the design against it on every clock.

// File: rtl/pkrf_pkg.sv
package pkrf_pkg;
  typedef enum logic [1:0] {
    EW_B8  = 2'd0,
    EW_B16 = 2'd1,
    EW_B32 = 2'd2,
    EW_B64 = 2'd3
  } elw_e;
endpackage

// File: rtl/pkrf_addr.sv
module pkrf_addr #(
  parameter int unsigned NUM_REGS  = 128,
  parameter int unsigned REG_BYTES = 8,
  parameter int unsigned IDX_W     = 7,
  localparam int unsigned REG_W    = $clog2(NUM_REGS),
  localparam int unsigned LANE_W   = $clog2(REG_BYTES),
  localparam int unsigned EW_W     = $clog2(LANE_W + 1)
) (
  input  logic [REG_W-1:0]  base_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [EW_W-1:0]   ew_i,
  output logic [REG_W-1:0]  reg_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              err_o
);
  localparam int unsigned WIDE_W = (REG_W > IDX_W) ? REG_W : IDX_W;
  localparam int unsigned OFF_W  = WIDE_W + LANE_W + 1;
  localparam int unsigned HI_W   = OFF_W - LANE_W;

  logic [OFF_W-1:0] base_off, elem_off, abs_off;
  logic [HI_W-1:0]  reg_full;

  assign base_off = OFF_W'(base_i) << LANE_W;
  assign elem_off = OFF_W'(idx_i) << ew_i;
  assign abs_off  = base_off + elem_off;
  assign reg_full = abs_off[OFF_W-1:LANE_W];
  assign lane_o   = abs_off[LANE_W-1:0];
  assign reg_o    = reg_full[REG_W-1:0];
  assign err_o    = reg_full >= HI_W'(NUM_REGS);
endmodule

// File: rtl/pkrf_wlane.sv
module pkrf_wlane #(
  parameter int unsigned REG_BYTES = 8,
  localparam int unsigned LANE_W   = $clog2(REG_BYTES),
  localparam int unsigned EW_W     = $clog2(LANE_W + 1),
  localparam int unsigned DATA_W   = REG_BYTES * 8
) (
  input  logic [EW_W-1:0]      ew_i,
  input  logic [LANE_W-1:0]    lane_i,
  input  logic [DATA_W-1:0]    data_i,
  output logic [REG_BYTES-1:0] be_o,
  output logic [DATA_W-1:0]    data_o
);
  logic [LANE_W:0] lane_end;

  // end lane is exclusive, one bit wider than a lane index
  assign lane_end = {1'b0, lane_i} + ((LANE_W + 1)'(1) << ew_i);

  for (genvar b = 0; b < REG_BYTES; b++) begin : g_be
    assign be_o[b] = ((LANE_W + 1)'(b) >= {1'b0, lane_i}) && ((LANE_W + 1)'(b) < lane_end);
  end

  // bits shifted past the covered lanes are dropped by be_o
  assign data_o = data_i << {lane_i, 3'b000};
endmodule

// File: rtl/pkrf_rlane.sv
module pkrf_rlane #(
  parameter int unsigned REG_BYTES = 8,
  localparam int unsigned LANE_W   = $clog2(REG_BYTES),
  localparam int unsigned EW_W     = $clog2(LANE_W + 1),
  localparam int unsigned DATA_W   = REG_BYTES * 8
) (
  input  logic [EW_W-1:0]   ew_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic              kill_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] elem_o
);
  logic [DATA_W-1:0] mask, shifted;

  for (genvar k = 0; k < DATA_W; k++) begin : g_mask
    assign mask[k] = (32'(k) >> 3) < (32'd1 << ew_i);
  end

  assign shifted = word_i >> {lane_i, 3'b000};
  assign elem_o  = kill_i ? '0 : (shifted & mask);
endmodule

// File: rtl/pkrf_store.sv
module pkrf_store #(
  parameter int unsigned NUM_REGS  = 128,
  parameter int unsigned REG_BYTES = 8,
  localparam int unsigned REG_W    = $clog2(NUM_REGS),
  localparam int unsigned DATA_W   = REG_BYTES * 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [REG_W-1:0]                  wreg_i,
  input  logic [REG_BYTES-1:0]              be_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]   file_o
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic hit;
    assign hit = we_i && (wreg_i == REG_W'(r));
    for (genvar b = 0; b < REG_BYTES; b++) begin : g_byte
      logic [7:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                q <= 8'h00;
        else if (hit && be_i[b])    q <= wdata_i[8*b +: 8];
      end
      assign file_o[r][8*b +: 8] = q;
    end
  end
endmodule

// File: rtl/pkrf_top.sv
module pkrf_top #(
  parameter int unsigned NUM_REGS  = 128,
  parameter int unsigned REG_BYTES = 8,
  parameter int unsigned IDX_W     = 7,
  localparam int unsigned REG_W    = $clog2(NUM_REGS),
  localparam int unsigned LANE_W   = $clog2(REG_BYTES),
  localparam int unsigned EW_W     = $clog2(LANE_W + 1),
  localparam int unsigned DATA_W   = REG_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_W-1:0]  rd_base_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [EW_W-1:0]   rd_ew_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_err_o,
  input  logic              wr_en_i,
  input  logic              add_i,
  input  logic [REG_W-1:0]  wr_base_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [EW_W-1:0]   wr_ew_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_err_o
);
  logic [REG_W-1:0]                rd_reg, wr_reg;
  logic [LANE_W-1:0]               rd_lane, wr_lane;
  logic [NUM_REGS-1:0][DATA_W-1:0] file_q;
  logic [DATA_W-1:0]               wr_operand, wr_aligned;
  logic [REG_BYTES-1:0]            wr_be;
  logic                            wr_fire;

  pkrf_addr #(.NUM_REGS(NUM_REGS), .REG_BYTES(REG_BYTES), .IDX_W(IDX_W)) u_rd_addr (
    .base_i(rd_base_i), .idx_i(rd_idx_i), .ew_i(rd_ew_i),
    .reg_o(rd_reg), .lane_o(rd_lane), .err_o(rd_err_o)
  );

  pkrf_addr #(.NUM_REGS(NUM_REGS), .REG_BYTES(REG_BYTES), .IDX_W(IDX_W)) u_wr_addr (
    .base_i(wr_base_i), .idx_i(wr_idx_i), .ew_i(wr_ew_i),
    .reg_o(wr_reg), .lane_o(wr_lane), .err_o(wr_err_o)
  );

  pkrf_rlane #(.REG_BYTES(REG_BYTES)) u_rlane (
    .ew_i(rd_ew_i), .lane_i(rd_lane), .kill_i(rd_err_o),
    .word_i(file_q[rd_reg]), .elem_o(rd_data_o)
  );

  // add result wraps naturally: lanes above the element are not enabled
  assign wr_operand = add_i ? (rd_data_o + wr_data_i) : wr_data_i;
  assign wr_fire    = wr_en_i && !wr_err_o && !(add_i && rd_err_o);

  pkrf_wlane #(.REG_BYTES(REG_BYTES)) u_wlane (
    .ew_i(wr_ew_i), .lane_i(wr_lane), .data_i(wr_operand),
    .be_o(wr_be), .data_o(wr_aligned)
  );

  pkrf_store #(.NUM_REGS(NUM_REGS), .REG_BYTES(REG_BYTES)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_fire), .wreg_i(wr_reg),
    .be_i(wr_be), .wdata_i(wr_aligned), .file_o(file_q)
  );
endmodule

// File: rtl/pkrf_chk.sv
module pkrf_chk #(
  parameter int unsigned NUM_REGS  = 128,
  parameter int unsigned REG_BYTES = 8,
  parameter int unsigned IDX_W     = 7,
  localparam int unsigned REG_W    = $clog2(NUM_REGS),
  localparam int unsigned LANE_W   = $clog2(REG_BYTES),
  localparam int unsigned EW_W     = $clog2(LANE_W + 1),
  localparam int unsigned DATA_W   = REG_BYTES * 8
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic [REG_W-1:0]                  rd_base_i,
  input logic [IDX_W-1:0]                  rd_idx_i,
  input logic [EW_W-1:0]                   rd_ew_i,
  input logic [DATA_W-1:0]                 rd_data_o,
  input logic                              rd_err_o,
  input logic                              wr_en_i,
  input logic                              wr_err_o,
  input logic [EW_W-1:0]                   wr_ew_i,
  input logic                              wr_fire,
  input logic [REG_BYTES-1:0]              wr_be,
  input logic [NUM_REGS-1:0][DATA_W-1:0]   file_q
);
  assert_wr_err_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_err_o) |=> $stable(file_q));

  assert_rd_err_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> (rd_data_o == '0));

  assert_be_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire |-> ($countones(wr_be) == (32'd1 << wr_ew_i)));

  assert_zext_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(rd_ew_i) < LANE_W) |-> ((rd_data_o >> (32'd8 << rd_ew_i)) == '0));

  assert_rd_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(rd_base_i) && $stable(rd_idx_i) && $stable(rd_ew_i) && !$past(wr_en_i))
      |-> $stable(rd_data_o));
endmodule

bind pkrf_top pkrf_chk #(.NUM_REGS(NUM_REGS), .REG_BYTES(REG_BYTES), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_base_i(rd_base_i), .rd_idx_i(rd_idx_i),
  .rd_ew_i(rd_ew_i), .rd_data_o(rd_data_o), .rd_err_o(rd_err_o), .wr_en_i(wr_en_i),
  .wr_err_o(wr_err_o), .wr_ew_i(wr_ew_i), .wr_fire(wr_fire), .wr_be(wr_be),
  .file_q(file_q)
);

// File: tb/tb_pkrf_top.sv
module tb_pkrf_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  rd_base = '0, rd_idx = '0, wr_base = '0, wr_idx = '0;
  logic [1:0]  rd_ew = '0, wr_ew = '0;
  logic [63:0] rd_data, wr_data = '0;
  logic        rd_err, wr_err, wr_en = 1'b0, add = 1'b0;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0]  mdl [1024];
  logic [63:0] last_rd;

  always #10 clk = ~clk;

  pkrf_top dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_base_i(rd_base), .rd_idx_i(rd_idx), .rd_ew_i(rd_ew),
    .rd_data_o(rd_data), .rd_err_o(rd_err), .wr_en_i(wr_en), .add_i(add),
    .wr_base_i(wr_base), .wr_idx_i(wr_idx), .wr_ew_i(wr_ew), .wr_data_i(wr_data),
    .wr_err_o(wr_err)
  );

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int off_of(input logic [6:0] b, input logic [6:0] i, input logic [1:0] e);
    return int'(b) * 8 + int'(i) * (1 << e);
  endfunction

  function automatic logic [63:0] mread(input logic [6:0] b, input logic [6:0] i, input logic [1:0] e);
    int o = off_of(b, i, e);
    logic [63:0] v = '0;
    if (o / 8 > 127) return '0;
    for (int k = 0; k < (1 << e); k++) v[8*k +: 8] = mdl[o + k];
    return v;
  endfunction

  task automatic cyc(input logic we, input logic ad,
                     input logic [6:0] rb, input logic [6:0] ri, input logic [1:0] re,
                     input logic [6:0] wb, input logic [6:0] wi, input logic [1:0] wq,
                     input logic [63:0] wd, input string tag);
    logic [63:0] exp_rd, val;
    logic exp_rerr, exp_werr;
    int wo;
    @(negedge clk);
    wr_en = we; add = ad; rd_base = rb; rd_idx = ri; rd_ew = re;
    wr_base = wb; wr_idx = wi; wr_ew = wq; wr_data = wd;
    #5;
    exp_rerr = (off_of(rb, ri, re) / 8) > 127;
    exp_werr = (off_of(wb, wi, wq) / 8) > 127;
    exp_rd   = mread(rb, ri, re);
    check(rd_data, exp_rd, {tag, " rd_data"});
    check(64'(rd_err), 64'(exp_rerr), {tag, " rd_err R8"});
    check(64'(wr_err), 64'(exp_werr), {tag, " wr_err R8"});
    last_rd = rd_data;
    val = ad ? exp_rd + wd : wd;
    wo = off_of(wb, wi, wq);
    @(posedge clk);
    if (we && !exp_werr && !(ad && exp_rerr))
      for (int k = 0; k < (1 << wq); k++) mdl[wo + k] = val[8*k +: 8];
  endtask

  task automatic wr64(input logic [6:0] r, input logic [63:0] d, input string tag);
    cyc(1, 0, r, 0, 3, r, 0, 3, d, tag);
  endtask

  task automatic rd_expect(input logic [6:0] b, input logic [6:0] i, input logic [1:0] e,
                           input logic [63:0] exp, input string tag);
    cyc(0, 0, b, i, e, 0, 0, 0, 0, tag);
    check(last_rd, exp, {tag, " explicit"});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 1024; k++) mdl[k] = 8'h00;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;

    // R1
    rd_expect(0, 0, 3, 64'h0, "R1 reg0");
    rd_expect(127, 0, 3, 64'h0, "R1 reg127");
    rd_expect(64, 3, 1, 64'h0, "R1 reg64 half");

    // R6
    wr64(5, 64'h1234, "R6 set");
    cyc(1, 1, 5, 0, 3, 5, 0, 3, 64'h1122, "R6 add");
    rd_expect(5, 0, 3, 64'h2356, "R6 full add");

    // R3
    wr64(6, 64'h0000_1144_5566_7788, "R3 set6");
    cyc(1, 0, 0, 0, 0, 6, 0, 1, 64'h1122, "R3 w16");
    rd_expect(6, 0, 3, 64'h0000_1144_5566_1122, "R3 16-bit lanes");
    wr64(7, 64'h0000_1144_5566_7788, "R3 set7");
    cyc(1, 0, 0, 0, 0, 7, 0, 2, 64'hAABB_CCDD, "R3 w32");
    rd_expect(7, 0, 3, 64'h0000_1144_AABB_CCDD, "R3 32-bit lanes");

    // R5
    wr64(8, 64'hFFFF, "R5 set8");
    cyc(1, 1, 8, 0, 1, 8, 0, 1, 64'h1, "R5 add16");
    rd_expect(8, 0, 3, 64'h0, "R5 wrap to zero");
    wr64(9, 64'hFFFF_FFFF_FFFF_FFFF, "R5 set9");
    cyc(1, 1, 9, 0, 1, 9, 0, 1, 64'h1, "R5 add16 ones");
    rd_expect(9, 0, 3, 64'hFFFF_FFFF_FFFF_0000, "R5 wrap in element");

    // R2, R4
    cyc(1, 0, 0, 0, 0, 10, 9, 0, 64'h5A, "R2 w8 idx9");
    cyc(1, 0, 0, 0, 0, 10, 5, 1, 64'hBEEF, "R2 w16 idx5");
    rd_expect(11, 0, 3, 64'h0000_0000_BEEF_5A00, "R2 spill into next reg");
    rd_expect(10, 11, 0, 64'hBE, "R4 byte read zext");
    rd_expect(10, 5, 1, 64'hBEEF, "R4 half read zext");
    rd_expect(9, 1, 2, 64'hFFFF_FFFF, "R4 word read zext");

    // R9
    cyc(1, 0, 0, 0, 0, 12, 0, 0, 64'hFFFF_FFFF_FFFF_FF33, "R9 w8");
    rd_expect(12, 0, 3, 64'h33, "R9 upper bits ignored");

    // R7
    cyc(1, 0, 13, 0, 3, 13, 0, 3, 64'hCAFE, "R7 rw same");
    check(last_rd, 64'h0, "R7 old data same cycle");
    rd_expect(13, 0, 3, 64'hCAFE, "R7 new data after edge");

    // R8
    cyc(1, 0, 0, 0, 3, 127, 1, 3, 64'hDEAD, "R8 wr over end");
    rd_expect(0, 0, 3, 64'h0, "R8 no wrap to reg0");
    rd_expect(127, 8, 0, 64'h0, "R8 read over end");
    check(64'(rd_err), 64'h1, "R8 rd_err held");
    wr64(127, 64'h77, "R8 set127");
    cyc(1, 1, 127, 64, 1, 127, 0, 3, 64'h1, "R8 add read over end");
    rd_expect(127, 0, 3, 64'h77, "R8 add suppressed");

    // random run against the byte model (R2)
    for (int n = 0; n < 600; n++) begin
      cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          7'($urandom_range(100, 127)), 7'($urandom_range(0, 127)), 2'($urandom),
          7'($urandom_range(100, 127)), 7'($urandom_range(0, 127)), 2'($urandom),
          {$urandom, $urandom}, "R2 random");
    end

    finish_run();
  end
endmodule